// File: doc/BRIEF.md
# Audio Transmit Buffer with Underrun Hold

This block sits between a processor and the serial audio transmitter for one audio channel. Software writes samples through a programmed-I/O write port. The transmitter takes one sample from the head of the buffer on each frame fetch strobe. When a fetch finds the buffer empty, the block does not output silence or stale memory. It keeps presenting the last sample it handed out and records the event in a sticky underrun flag, which also drives an interrupt line.

Once software writes new data, the next fetch delivers that data and normal playback continues with no extra action. A not-full flag lets software poll for free space. That flag never raises an interrupt. A stereo system uses two instances, one for each channel.

Top module: `audio_tx_hold_fifo`

## Requirements
- R1: After reset, `sampleOut` is 0, `notFull` is 1, and `underrun` and `irq` are 0.
- R2: Samples leave in the order they were written. `sampleOut` takes the head sample at the clock edge that samples `fetchStb` high, and it does not change on cycles without a fetch.
- R3: The buffer holds `DEPTH` (default 12) samples. `notFull` is 0 exactly when all `DEPTH` entries hold data, and 1 otherwise.
- R4: A write while the buffer holds `DEPTH` samples is dropped, even when a fetch happens in the same cycle. The stored samples and their order are unchanged.
- R5: A fetch while the buffer is empty sets `underrun` and leaves `sampleOut` at the last sample delivered. If no sample has been delivered since reset, `sampleOut` stays 0.
- R6: After an underrun, the first fetch that follows a write delivers the newly written sample.
- R7: `underrun` stays set until a cycle with `undClr` high clears it. If a fetch on an empty buffer happens in the same cycle as `undClr`, `underrun` ends up set.
- R8: `irq` is high exactly when `underrun` is high. A full buffer (`notFull` = 0) does not raise `irq`.
- R9: When a write and a fetch arrive in the same cycle on an empty buffer, the fetch counts as an underrun and the written sample is kept for the next fetch.
- R10: When a write and a fetch arrive in the same cycle on a buffer that is neither empty nor full, both happen and the fill level does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrData | input | DATA_W | Sample to write |
| wrStb | input | 1 | Write strobe |
| fetchStb | input | 1 | Fetch strobe from the transmitter, one per frame |
| undClr | input | 1 | Clear strobe for the underrun flag |
| sampleOut | output | DATA_W | Sample presented to the transmitter |
| notFull | output | 1 | High while at least one entry is free |
| underrun | output | 1 | Sticky flag: a fetch found the buffer empty |
| irq | output | 1 | Interrupt request, follows `underrun` |

## Verification
The bench covers the following corner cases and the failure each one would expose:
- **Fetch on an empty buffer.** A wrong design would zero the output or read stale memory where it should hold the last delivered sample.
- **Fetch right after reset.** A design that left the held register unreset would output an unknown value here.
- **`undClr` in the same cycle as an empty fetch.** A design where the clear wins would lose an underrun event.
- **Write while full, with and without a simultaneous fetch.** A design that accepted the write would overwrite the oldest sample, or a later sample would appear in the drain sequence.
- **Write and fetch together on an empty buffer.** A design that bypassed the write to the output would hide the underrun, and one that dropped the write would lose the sample.

// File: rtl/atx_pkg.sv
package atx_pkg;

  // Strobes from control to datapath for one clock cycle
  typedef struct packed {
    logic push;   // store wrData at the tail
    logic pop;    // move the head sample to the output register
  } atxStrobes_t;

endpackage

// File: rtl/atx_ctrl.sv
module atx_ctrl #(
  parameter int DEPTH = 12,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrStb,
  input  logic                    fetchStb,
  input  logic                    undClr,
  output atx_pkg::atxStrobes_t    stb,
  output logic                    notFull,
  output logic                    underrun
);

  logic [CNT_W-1:0] fillCnt;
  logic             isFull;
  logic             isEmpty;
  logic             emptyFetch;

  assign isFull     = (fillCnt == CNT_W'(DEPTH));
  assign isEmpty    = (fillCnt == '0);
  assign stb.push   = wrStb && !isFull;
  assign stb.pop    = fetchStb && !isEmpty;
  assign emptyFetch = fetchStb && isEmpty;
  assign notFull    = !isFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt <= '0;
    end else if (stb.push && !stb.pop) begin
      fillCnt <= fillCnt + 1'b1;
    end else if (stb.pop && !stb.push) begin
      fillCnt <= fillCnt - 1'b1;
    end
  end

  // Setting the flag takes precedence over clearing it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      underrun <= 1'b0;
    end else if (emptyFetch) begin
      underrun <= 1'b1;
    end else if (undClr) begin
      underrun <= 1'b0;
    end
  end

endmodule

// File: rtl/atx_datapath.sv
module atx_datapath #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 12,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  atx_pkg::atxStrobes_t stb,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    sampleOut
);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (stb.push) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.push) wrPtr <= bump(wrPtr);
      if (stb.pop)  rdPtr <= bump(rdPtr);
    end
  end

  // Output register: loaded only on a successful pop, held otherwise
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleOut <= '0;
    end else if (stb.pop) begin
      sampleOut <= store[rdPtr];
    end
  end

endmodule

// File: rtl/audio_tx_hold_fifo.sv
module audio_tx_hold_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrStb,
  input  logic              fetchStb,
  input  logic              undClr,
  output logic [DATA_W-1:0] sampleOut,
  output logic              notFull,
  output logic              underrun,
  output logic              irq
);

  atx_pkg::atxStrobes_t stb;

  atx_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrStb    (wrStb),
    .fetchStb (fetchStb),
    .undClr   (undClr),
    .stb      (stb),
    .notFull  (notFull),
    .underrun (underrun)
  );

  atx_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .sampleOut (sampleOut)
  );

  assign irq = underrun;

endmodule

// File: rtl/atx_chk.sv
module atx_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 12,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrStb,
  input logic              fetchStb,
  input logic              undClr,
  input logic [DATA_W-1:0] sampleOut,
  input logic              notFull,
  input logic              underrun,
  input logic              irq
);

  // Independent fill model built only from the port strobes
  logic [CNT_W-1:0] shadowCnt;
  logic             shPush;
  logic             shPop;

  assign shPush = wrStb && (shadowCnt != CNT_W'(DEPTH));
  assign shPop  = fetchStb && (shadowCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN)               shadowCnt <= '0;
    else if (shPush && !shPop) shadowCnt <= shadowCnt + 1'b1;
    else if (shPop && !shPush) shadowCnt <= shadowCnt - 1'b1;
  end

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fetchStb |=> $stable(sampleOut));

  // R3
  full_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    notFull == (shadowCnt != CNT_W'(DEPTH)));

  // R5
  empty_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchStb && shadowCnt == '0) |=> (underrun && $stable(sampleOut)));

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !undClr) |=> underrun);

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (undClr && !(fetchStb && shadowCnt == '0)) |=> !underrun);

  // R8
  irq_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq == underrun);

endmodule

bind audio_tx_hold_fifo atx_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .wrStb     (wrStb),
  .fetchStb  (fetchStb),
  .undClr    (undClr),
  .sampleOut (sampleOut),
  .notFull   (notFull),
  .underrun  (underrun),
  .irq       (irq)
);

// File: tb/sim_audio_tx_hold_fifo.sv
module sim_audio_tx_hold_fifo;

  localparam int DW = 16;
  localparam int DP = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic          wrStb = 1'b0;
  logic          fetchStb = 1'b0;
  logic          undClr = 1'b0;
  logic [DW-1:0] sampleOut;
  logic          notFull;
  logic          underrun;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  audio_tx_hold_fifo #(.DATA_W(DW), .DEPTH(DP)) u0 (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrStb(wrStb),
    .fetchStb(fetchStb), .undClr(undClr), .sampleOut(sampleOut),
    .notFull(notFull), .underrun(underrun), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // Inputs applied after a falling edge, held through one rising edge,
  // outputs observed at the next falling edge
  task automatic step(input bit w, input logic [DW-1:0] d, input bit f, input bit c);
    wrStb = w; wrData = d; fetchStb = f; undClr = c;
    @(negedge clk);
    wrStb = 1'b0; fetchStb = 1'b0; undClr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 sampleOut", sampleOut, 0);
    check("R1 notFull", notFull, 1);
    check("R1 underrun", underrun, 0);
    check("R1 irq", irq, 0);
    step(0, '0, 1, 0);
    check("R5 underrun after reset fetch", underrun, 1);
    check("R5 zero held after reset", sampleOut, 0);
    step(0, '0, 0, 1);
  endtask

  task automatic t_order();
    step(1, 16'hA001, 0, 0);
    step(1, 16'hA002, 0, 0);
    step(1, 16'hA003, 0, 0);
    check("R2 no fetch keeps output", sampleOut, 0);
    step(0, '0, 1, 0);
    check("R2 first", sampleOut, 16'hA001);
    step(0, '0, 0, 0);
    check("R2 holds between fetches", sampleOut, 16'hA001);
    step(0, '0, 1, 0);
    check("R2 second", sampleOut, 16'hA002);
    step(0, '0, 1, 0);
    check("R2 third", sampleOut, 16'hA003);
    check("R2 no underrun yet", underrun, 0);
  endtask

  task automatic t_underrun_hold();
    step(0, '0, 1, 0);
    check("R5 underrun set", underrun, 1);
    check("R8 irq set", irq, 1);
    check("R5 last held", sampleOut, 16'hA003);
    step(0, '0, 1, 0);
    check("R5 still held", sampleOut, 16'hA003);
    step(0, '0, 0, 0);
    check("R7 sticky", underrun, 1);
  endtask

  task automatic t_clear();
    step(0, '0, 0, 1);
    check("R7 cleared", underrun, 0);
    check("R8 irq cleared", irq, 0);
    step(0, '0, 1, 1);
    check("R7 set wins over clear", underrun, 1);
    step(0, '0, 0, 1);
    check("R7 cleared again", underrun, 0);
  endtask

  task automatic t_resume();
    step(1, 16'hB001, 0, 0);
    step(0, '0, 1, 0);
    check("R6 resumes with new data", sampleOut, 16'hB001);
    check("R6 no new underrun", underrun, 0);
  endtask

  task automatic t_simul_empty();
    step(1, 16'hC001, 1, 0);
    check("R9 underrun on write+fetch empty", underrun, 1);
    check("R9 output held", sampleOut, 16'hB001);
    step(0, '0, 1, 1);
    check("R9 kept sample delivered", sampleOut, 16'hC001);
    check("R9 no underrun on that fetch", underrun, 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < DP; i++) begin
      step(1, DW'(16'hD000 + i), 0, 0);
      check("R3 notFull while filling", notFull, (i == DP - 1) ? 1'b0 : 1'b1);
    end
    check("R8 full raises no irq", irq, 0);
    step(1, 16'hDEAD, 0, 0);
    check("R4 still full", notFull, 0);
    step(1, 16'hBEEF, 1, 0);
    check("R4 head popped", sampleOut, 16'hD000);
    check("R4 write dropped, not full", notFull, 1);
    for (int i = 1; i < DP; i++) begin
      step(0, '0, 1, 0);
      check("R4 drain order intact", sampleOut, DW'(16'hD000 + i));
    end
    step(0, '0, 1, 0);
    check("R4 empty after drain", underrun, 1);
    check("R5 hold after drain", sampleOut, 16'hD00B);
    step(0, '0, 0, 1);
  endtask

  task automatic t_simul_mid();
    step(1, 16'hE000, 0, 0);
    step(1, 16'hE001, 0, 0);
    step(1, 16'hE002, 1, 0);
    check("R10 pop during write", sampleOut, 16'hE000);
    step(0, '0, 1, 0);
    check("R10 next", sampleOut, 16'hE001);
    step(0, '0, 1, 0);
    check("R10 written kept", sampleOut, 16'hE002);
    check("R10 no underrun", underrun, 0);
    step(0, '0, 1, 0);
    check("R10 level unchanged then empty", underrun, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_underrun_hold();
    t_clear();
    t_resume();
    t_simul_empty();
    t_full();
    t_simul_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule